// File: doc/BRIEF.md
# Real-Time Clock Register Interface

This block presents a PC-style real-time clock to software as fourteen byte registers reached through a pair of ports. An index write picks the register. A data read or a data write then reaches the register that the index names. Indices 0 to 9 hold clock and calendar bytes, which are loaded with a build-time date and time at reset. Indices 0xA to 0xD are status registers. The block guards them: software may only write values the block supports, and any other write raises a one-cycle error pulse and changes nothing.

While the periodic-interrupt enable bit in status register B is set, a free-running interval counter emits a one-cycle interrupt pulse every `INTERVAL` clock cycles. Clearing the bit stops the pulses. Setting it again restarts the count from zero. The block does not advance the time of day by itself.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, `rdata` is 0x00, `err` and `irq` are low, and the index is 0. The calendar bytes hold their initial values in this order: 0 seconds, 2 minutes, 4 hours, 6 weekday, 7 day of month, 8 month, 9 year. Bytes 1, 3 and 5 are 0x00.
- R2: An index write of a value up to 0x0D selects that register. A larger value pulses `err` in the next cycle and leaves the index unchanged.
- R3: A data write to index 0 to 9 stores the byte. A data read of index 0 to 9 returns the stored byte on `rdata` in the cycle after the strobe, and `rdata` holds until the next read. A read never raises `err`.
- R4: Register A resets to 0x26. Each data read of A inverts bit 7 (update in progress) and returns the inverted value.
- R5: Only the value 0x26 may be written to register A. Any other value pulses `err` and leaves A unchanged.
- R6: Register B resets to 0x46: bit 6 interrupt enable, bit 2 binary, bit 1 24-hour. A write is accepted only if `(value & 0xB7) == 0x06`, so only bit 6 and bit 3 (square-wave enable) are free. Any other value pulses `err` and leaves B unchanged.
- R7: Registers C (0x0C) and D (0x0D) read as 0x00, and any write to them pulses `err`.
- R8: While B bit 6 is set, `irq` is a one-cycle pulse that repeats every `INTERVAL` cycles. The first pulse comes `INTERVAL` cycles after reset is released.
- R9: An accepted B write with bit 6 clear stops `irq` at once. An accepted B write with bit 6 set starts a fresh count only if the timer was stopped, and the first pulse then comes `INTERVAL` cycles after the write. If the timer is already running, such a write leaves its phase alone.
- R10: With `YEAR_BCD` set, the year byte is the last two decimal digits of the year in BCD, tens in bits 7:4 and ones in bits 3:0. Without it, the year byte is the year minus 1900. The weekday runs 1 to 7 with 1 for Sunday, and the month runs 1 to 12.
- R11: When an index write and a data access fall in the same cycle, the data access uses the index held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_wr | input | 1 | Index write strobe |
| dat_wr | input | 1 | Data write strobe to the selected register |
| dat_rd | input | 1 | Data read strobe from the selected register |
| wdata | input | 8 | Write byte for an index write or a data write |
| rdata | output | 8 | Byte returned by the latest data read |
| err | output | 1 | One-cycle pulse for a rejected access |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The hardest case to reach is the interaction between the periodic timer and B writes. A stop, a restart and a redundant enable all have to land at chosen points in the interval. The stimulus therefore writes B at known cycles: first with the enable clear, then set, then set again while the timer runs. It then counts cycles to the next pulse. The bench model tracks the timer phase on every clock, so any restart or lost pulse caused by a redundant enable shows up as an `irq` mismatch.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int          IDX_W      = 4;
    localparam int          NUM_CAL    = 10;
    localparam logic [3:0]  IDX_A      = 4'hA;
    localparam logic [3:0]  IDX_B      = 4'hB;
    localparam logic [3:0]  IDX_C      = 4'hC;
    localparam logic [7:0]  MAX_IDX    = 8'h0D;

    // status register A: 32.768 kHz base, 1024 Hz rate, bit 7 update flag
    localparam logic [7:0]  A_RESET    = 8'h26;
    localparam int          UIP_BIT    = 7;

    // status register B
    localparam int          PIE_BIT    = 6;
    localparam int          SQW_BIT    = 3;
    localparam int          BIN_BIT    = 2;
    localparam int          H24_BIT    = 1;
    localparam logic [7:0]  B_RESET    = 8'h46;
    localparam logic [7:0]  B_FREE     = (8'h01 << PIE_BIT) | (8'h01 << SQW_BIT);
    localparam logic [7:0]  B_FIXED    = (8'h01 << BIN_BIT) | (8'h01 << H24_BIT);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       rdata;
        logic             err;
    } front_t;

endpackage

// File: rtl/rtc_cal_store.sv
module rtc_cal_store
    import rtc_pkg::*;
#(
    parameter int INIT_YEAR  = 2024,
    parameter bit YEAR_BCD   = 1'b1,
    parameter int INIT_MONTH = 3,
    parameter int INIT_MDAY  = 15,
    parameter int INIT_WDAY  = 6,
    parameter int INIT_HOUR  = 13,
    parameter int INIT_MIN   = 45,
    parameter int INIT_SEC   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    localparam int YEAR_CODE = YEAR_BCD ?
        ((((INIT_YEAR % 100) / 10) * 16) + (INIT_YEAR % 10)) :
        (INIT_YEAR - 1900);

    function automatic logic [7:0] init_byte(input int i);
        case (i)
            0:       return 8'(INIT_SEC);
            2:       return 8'(INIT_MIN);
            4:       return 8'(INIT_HOUR);
            6:       return 8'(INIT_WDAY);
            7:       return 8'(INIT_MDAY);
            8:       return 8'(INIT_MONTH);
            9:       return 8'(YEAR_CODE);
            default: return 8'h00;
        endcase
    endfunction

    logic [7:0] mem_d [NUM_CAL];
    logic [7:0] mem_q [NUM_CAL];

    always_comb begin
        for (int i = 0; i < NUM_CAL; i++) begin
            mem_d[i] = mem_q[i];
            if (we && (int'(idx) == i)) mem_d[i] = wdata;
        end
    end

    for (genvar g = 0; g < NUM_CAL; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= init_byte(g);
            else        mem_q[g] <= mem_d[g];
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_CAL; i++) begin
            if (int'(idx) == i) rdata = mem_q[i];
        end
    end

endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_a,
    input  logic       wr_b,
    input  logic       rd_a,
    input  logic [7:0] wdata,
    output logic [7:0] stat_a,
    output logic [7:0] stat_b,
    output logic [7:0] a_read_val,
    output logic       a_bad,
    output logic       b_bad,
    output logic       pie_start,
    output logic       pie_stop
);

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
    } stat_t;

    stat_t st_d, st_q;
    logic  b_ok;

    always_comb begin
        st_d       = st_q;
        a_bad      = wr_a && (wdata != A_RESET);
        b_ok       = ((wdata & ~B_FREE) == B_FIXED);
        b_bad      = wr_b && !b_ok;
        pie_start  = wr_b && b_ok && wdata[PIE_BIT];
        pie_stop   = wr_b && b_ok && !wdata[PIE_BIT];
        a_read_val = st_q.a ^ (8'h01 << UIP_BIT);

        if (wr_a && !a_bad)  st_d.a = wdata;
        else if (rd_a)       st_d.a = a_read_val;

        if (wr_b && b_ok)    st_d.b = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a <= A_RESET;
            st_q.b <= B_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_a = st_q.a;
    assign stat_b = st_q.b;

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic pulse
);

    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (stop) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (start && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run   <= 1'b1;
            st_q.cnt   <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int INTERVAL   = 1024,
    parameter int INIT_YEAR  = 2024,
    parameter bit YEAR_BCD   = 1'b1,
    parameter int INIT_MONTH = 3,
    parameter int INIT_MDAY  = 15,
    parameter int INIT_WDAY  = 6,
    parameter int INIT_HOUR  = 13,
    parameter int INIT_MIN   = 45,
    parameter int INIT_SEC   = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       err,
    output logic       irq
);

    front_t st_d, st_q;

    logic             is_cal, cal_we;
    logic             wr_a, wr_b, rd_a;
    logic             idx_bad, cd_bad;
    logic             a_bad, b_bad, pie_start, pie_stop;
    logic [7:0]       cal_rdata, stat_a, stat_b, a_read_val;
    logic [7:0]       rd_mux;
    logic [IDX_W-1:0] idx_cur;

    assign idx_cur = st_q.idx;

    rtc_cal_store #(
        .INIT_YEAR (INIT_YEAR),
        .YEAR_BCD  (YEAR_BCD),
        .INIT_MONTH(INIT_MONTH),
        .INIT_MDAY (INIT_MDAY),
        .INIT_WDAY (INIT_WDAY),
        .INIT_HOUR (INIT_HOUR),
        .INIT_MIN  (INIT_MIN),
        .INIT_SEC  (INIT_SEC)
    ) u_cal (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cal_we),
        .idx  (idx_cur),
        .wdata(wdata),
        .rdata(cal_rdata)
    );

    rtc_status_regs u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_a      (wr_a),
        .wr_b      (wr_b),
        .rd_a      (rd_a),
        .wdata     (wdata),
        .stat_a    (stat_a),
        .stat_b    (stat_b),
        .a_read_val(a_read_val),
        .a_bad     (a_bad),
        .b_bad     (b_bad),
        .pie_start (pie_start),
        .pie_stop  (pie_stop)
    );

    rtc_periodic #(
        .INTERVAL(INTERVAL)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(pie_start),
        .stop (pie_stop),
        .pulse(irq)
    );

    always_comb begin
        st_d    = st_q;
        is_cal  = (int'(st_q.idx) < NUM_CAL);
        cal_we  = dat_wr && is_cal;
        wr_a    = dat_wr && (st_q.idx == IDX_A);
        wr_b    = dat_wr && (st_q.idx == IDX_B);
        rd_a    = dat_rd && (st_q.idx == IDX_A);
        cd_bad  = dat_wr && (st_q.idx >= IDX_C);
        idx_bad = idx_wr && (wdata > MAX_IDX);

        if (is_cal)                   rd_mux = cal_rdata;
        else if (st_q.idx == IDX_A)   rd_mux = a_read_val;
        else if (st_q.idx == IDX_B)   rd_mux = stat_b;
        else                          rd_mux = 8'h00;

        if (dat_rd)              st_d.rdata = rd_mux;
        if (idx_wr && !idx_bad)  st_d.idx   = wdata[IDX_W-1:0];
        st_d.err = idx_bad | a_bad | b_bad | cd_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.rdata <= 8'h00;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idx_wr,
    input logic       dat_wr,
    input logic       dat_rd,
    input logic [7:0] wdata,
    input logic [3:0] idx_cur,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b,
    input logic [7:0] rdata,
    input logic       err,
    input logic       irq
);

    a_r2_bad_index_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wdata > 8'h0D) |=> err);

    a_r2_bad_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wdata > 8'h0D) |=> (idx_cur == $past(idx_cur)));

    a_r3_read_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !dat_wr && !idx_wr) |=> !err);

    a_r4_uip_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !dat_wr && idx_cur == 4'hA) |=> (stat_a[7] != $past(stat_a[7])));

    a_r5_a_rate_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        stat_a[6:0] == 7'h26);

    a_r6_b_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_b & 8'hB7) == 8'h06);

    a_r7_cd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && idx_cur >= 4'hC) |=> (rdata == 8'h00));

    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_b[6] |-> !irq);

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .dat_wr (dat_wr),
    .dat_rd (dat_rd),
    .wdata  (wdata),
    .idx_cur(idx_cur),
    .stat_a (stat_a),
    .stat_b (stat_b),
    .rdata  (rdata),
    .err    (err),
    .irq    (irq)
);

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;

    localparam int PER = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       err, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_regfile #(.INTERVAL(PER)) i_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
        .dat_rd(dat_rd), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
    );

    // behavioural reference model
    int m_mem [10];
    int m_idx, m_a, m_b, m_cnt, m_rd;
    bit m_run, m_irq, m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mem = '{30, 0, 45, 0, 13, 0, 6, 15, 3, 'h24};
            m_idx = 0; m_a = 'h26; m_b = 'h46; m_cnt = 0; m_rd = 0;
            m_run = 1; m_irq = 0; m_err = 0;
        end else begin
            bit ne, b_ok, b_acc;
            int w;
            w = int'(wdata);
            ne = 0; b_acc = 0; b_ok = 0;
            if (dat_rd) begin
                if (m_idx < 10) m_rd = m_mem[m_idx];
                else if (m_idx == 10) begin m_a = m_a ^ 'h80; m_rd = m_a; end
                else if (m_idx == 11) m_rd = m_b;
                else m_rd = 0;
            end
            if (dat_wr) begin
                if (m_idx < 10) m_mem[m_idx] = w;
                else if (m_idx == 10) begin
                    if (w == 'h26) m_a = w; else ne = 1;
                end else if (m_idx == 11) begin
                    b_ok = ((w & 'hB7) == 'h06);
                    if (b_ok) begin m_b = w; b_acc = 1; end else ne = 1;
                end else ne = 1;
            end
            m_irq = 0;
            if (b_acc && !w[6]) begin m_run = 0; m_cnt = 0; end
            else if (b_acc && w[6] && !m_run) begin m_run = 1; m_cnt = 0; end
            else if (m_run) begin
                if (m_cnt == PER - 1) begin m_cnt = 0; m_irq = 1; end
                else m_cnt++;
            end
            if (idx_wr) begin
                if (w <= 13) m_idx = w; else ne = 1;
            end
            m_err = ne;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            total += 3;
            if (rdata !== 8'(m_rd)) begin
                bad++; $display("FAIL R3 R4 rdata: actual=%02h expected=%02h", rdata, 8'(m_rd));
            end
            if (err !== m_err) begin
                bad++; $display("FAIL R2 R5 R6 R7 err: actual=%0b expected=%0b", err, m_err);
            end
            if (irq !== m_irq) begin
                bad++; $display("FAIL R8 R9 irq: actual=%0b expected=%0b", irq, m_irq);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input bit iw, input bit dw, input bit dr, input logic [7:0] d);
        @(negedge clk); #1;
        idx_wr = iw; dat_wr = dw; dat_rd = dr; wdata = d;
        @(negedge clk); #1;
        idx_wr = 0; dat_wr = 0; dat_rd = 0; wdata = 8'h00;
    endtask

    task automatic sel(input logic [7:0] i); op(1, 0, 0, i); endtask
    task automatic rd(); op(0, 0, 1, 8'h00); endtask
    task automatic wr(input logic [7:0] d); op(0, 1, 0, d); endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_cal [10];
        int n;
        exp_cal = '{30, 0, 45, 0, 13, 0, 6, 15, 3, 'h24};
        #20; rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 rdata reset", rdata, 0);
        chk("R1 err reset", err, 0);
        chk("R1 irq reset", irq, 0);

        // R1 / R10: initial calendar contents, BCD year
        for (int i = 0; i < 10; i++) begin
            sel(8'(i)); rd();
            chk(i == 9 ? "R10 year bcd" : "R1 init byte", rdata, exp_cal[i]);
        end

        // R3: storage write and read back
        sel(8'h03); wr(8'h5A); chk("R3 write err", err, 0);
        rd(); chk("R3 readback", rdata, 'h5A);

        // R4: update flag flips on each read
        sel(8'h0A); rd(); chk("R4 first read", rdata, 'hA6);
        rd(); chk("R4 second read", rdata, 'h26);

        // R5: bad write to A rejected
        wr(8'h27); chk("R5 bad write err", err, 1);
        rd(); chk("R5 A unchanged", rdata, 'hA6);
        wr(8'h26); chk("R5 good write err", err, 0);
        rd(); chk("R5 A after good write", rdata, 'hA6);

        // R6: register B checks
        sel(8'h0B); rd(); chk("R6 B reset", rdata, 'h46);
        wr(8'h10); chk("R6 bad write err", err, 1);
        rd(); chk("R6 B unchanged", rdata, 'h46);
        wr(8'h4E); chk("R6 sqw write err", err, 0);
        rd(); chk("R6 B sqw set", rdata, 'h4E);

        // R7: C and D
        sel(8'h0C); rd(); chk("R7 C read", rdata, 0);
        sel(8'h0D); rd(); chk("R7 D read", rdata, 0);
        wr(8'h00); chk("R7 D write err", err, 1);

        // R2: out-of-range index rejected, index kept
        sel(8'h07); sel(8'h0E); chk("R2 bad index err", err, 1);
        rd(); chk("R2 index kept", rdata, 15);
        sel(8'h0D); chk("R2 max index err", err, 0);

        // R11: index write and read in the same cycle use the old index
        sel(8'h04);
        op(1, 0, 1, 8'h02); chk("R11 old index used", rdata, 13);
        rd(); chk("R11 new index after", rdata, 45);

        // R8: period between pulses
        n = 0;
        while (!irq && n < 100) begin @(negedge clk); #1; n++; end
        n = 0;
        do begin @(negedge clk); #1; n++; end while (!irq && n < 100);
        chk("R8 period", n, PER);

        // R9: stop, then restart with fresh count
        sel(8'h0B); wr(8'h06); chk("R9 stop accepted", err, 0);
        n = 0;
        for (int k = 0; k < 3 * PER; k++) begin @(negedge clk); #1; if (irq) n++; end
        chk("R9 no pulses while off", n, 0);
        wr(8'h46);
        n = 0;
        do begin @(negedge clk); #1; n++; end while (!irq && n < 100);
        chk("R9 restart delay", n, PER);
        // redundant enable mid-interval must not shift phase
        for (int k = 0; k < 4; k++) @(negedge clk);
        wr(8'h46);
        n = 0;
        do begin @(negedge clk); #1; n++; end while (!irq && n < 100);
        chk("R9 phase kept", n, PER - 6);

        repeat (5) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule